// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory. Address, read/write select and chip select are registered on the rising clock edge. On a write, the data and byte enables arrive one cycle after the address. Write data waits in a one-entry buffer and reaches the array only when the next write's data is taken. A read that hits the buffered address gets the buffered bytes, merged lane by lane with the array word.

Reads pass through two registers: an internal capture stage and an output register. The data therefore appears two rising edges after the read command was sampled. When a non-read cycle follows, the outputs stay driven for one extra cycle before they switch off. High impedance is shown by a valid flag going low, not by tri-state logic. An output enable gates that flag without a clock. A sleep input blocks new commands.

The word width is 18 or 36 bits, made of 9-bit lanes. The array depth is a separate parameter, so the storage can stay small for simulation.

Top module: `lsw_sram`

## Requirements
- R1: A read command is accepted when `sel`=1, `we`=0 and `sleep`=0 at a rising edge k. Its data is on `dout` with `dq_vld`=1 (given `out_en`=1) after edge k+2.
- R2: A write command is accepted when `sel`=1, `we`=1 and `sleep`=0 at edge k. Its `din` and `be` are taken at edge k+1, not at edge k.
- R3: `be[i]`=1 writes `din[9*i+8:9*i]`. A lane whose enable is 0 keeps its previous contents.
- R4: The word is made of W/9 lanes (4 lanes at W=36). The top lane, bits 35:27, is written and read like the others.
- R5: A read issued in the cycle right after a write to the same address returns the new bytes, merged with the older word on the lanes that were not enabled.
- R6: Back-to-back writes to different addresses all land in memory. The buffered write moves to the array when the next write's data is taken.
- R7: After the last read's output cycle, `dq_vld` stays 1 for one more cycle and `dout` holds its value. In the cycle after that, `dq_vld` is 0.
- R8: `dq_vld` is 0 whenever `out_en` is 0. It follows `out_en` without waiting for a clock edge.
- R9: While `sleep`=1, read and write commands are ignored, and the memory contents stay as they were.
- R10: A synchronous reset (`rst`=1) drives `dq_vld` and `dout` to 0 and empties the write buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select, active high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | $clog2(DEPTH) | Word address |
| be | input | W/9 | Lane write enables, taken one cycle after the write address |
| din | input | W | Write data, taken one cycle after the write address |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Blocks new commands while high |
| dout | output | W | Registered read data |
| dq_vld | output | 1 | Outputs driven; 0 stands for high impedance |

## Verification
The assertions assume that `sel`, `we` and `sleep` are known at every rising edge after reset. They also assume that the byte enables matter only in the cycle that follows an accepted write. The timing checks count from commands that the checker itself decodes from those three pins.

The stimulus changes inputs only at falling edges. It drives `din` and `be` from the stored data of the previous accepted write, so late-write data always lines up with its address. It reads only addresses that were written earlier, so the array is never read before it holds known data.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic sel, input logic we, input logic sleep);
        if (sleep || !sel) return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction
endpackage

// File: rtl/lsw_cmd_reg.sv
module lsw_cmd_reg
    import lsw_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          we,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
        end else begin
            op_q   <= decode_op(sel, we, sleep);
            addr_q <= addr;
        end
    end
endmodule

// File: rtl/lsw_wbuf.sv
module lsw_wbuf
    import lsw_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 6,
    parameter int L  = W / LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] addr_q,
    input  logic [W-1:0]  din,
    input  logic [L-1:0]  be,
    input  logic [W-1:0]  arr_word,
    output logic          commit,
    output logic          pend_vld,
    output logic [AW-1:0] pend_addr,
    output logic [W-1:0]  pend_data,
    output logic [L-1:0]  pend_be,
    output logic [W-1:0]  fwd_word
);
    logic hit;

    assign commit = take && pend_vld;
    assign hit    = pend_vld && (pend_addr == addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            pend_be   <= '0;
        end else if (take) begin
            pend_vld  <= 1'b1;
            pend_addr <= addr_q;
            pend_data <= din;
            pend_be   <= be;
        end
    end

    for (genvar g = 0; g < L; g++) begin : g_fwd
        assign fwd_word[g*LANE_W +: LANE_W] = (hit && pend_be[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lsw_array.sv
module lsw_array
    import lsw_pkg::*;
#(
    parameter int W     = 36,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int L     = W / LANE_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [L-1:0]  wr_be,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] old_word;
    logic [W-1:0] new_word;

    assign old_word = mem[wr_addr];
    assign rd_word  = mem[rd_addr];

    for (genvar g = 0; g < L; g++) begin : g_lane
        assign new_word[g*LANE_W +: LANE_W] = wr_be[g]
            ? wr_data[g*LANE_W +: LANE_W]
            : old_word[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= new_word;
    end
endmodule

// File: rtl/lsw_out_stage.sv
module lsw_out_stage #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_now,
    input  logic [W-1:0] rd_word,
    input  logic         out_en,
    output logic [W-1:0] dout,
    output logic         dq_vld,
    output logic         drv_on
);
    logic         cap_vld;
    logic         cap_vld_d;
    logic [W-1:0] cap_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld   <= 1'b0;
            cap_vld_d <= 1'b0;
            cap_word  <= '0;
            dout      <= '0;
            drv_on    <= 1'b0;
        end else begin
            cap_vld   <= rd_now;
            cap_word  <= rd_word;
            cap_vld_d <= cap_vld;
            drv_on    <= cap_vld || cap_vld_d;
            if (cap_vld) dout <= cap_word;
        end
    end

    assign dq_vld = drv_on && out_en;
endmodule

// File: rtl/lsw_sram.sv
module lsw_sram
    import lsw_pkg::*;
#(
    parameter int W     = 36,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int L    = W / LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [L-1:0]  be,
    input  logic [W-1:0]  din,
    input  logic          out_en,
    input  logic          sleep,
    output logic [W-1:0]  dout,
    output logic          dq_vld
);
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic          commit;
    logic          pend_vld;
    logic [AW-1:0] pend_addr;
    logic [W-1:0]  pend_data;
    logic [L-1:0]  pend_be;
    logic [W-1:0]  arr_word;
    logic [W-1:0]  fwd_word;
    logic          drv_on;

    lsw_cmd_reg #(.AW(AW)) u_cmd (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .sleep(sleep),
        .addr(addr), .op_q(op_q), .addr_q(addr_q)
    );

    lsw_wbuf #(.W(W), .AW(AW), .L(L)) u_wbuf (
        .clk(clk), .rst(rst), .take(op_q == OP_WRITE), .addr_q(addr_q),
        .din(din), .be(be), .arr_word(arr_word), .commit(commit),
        .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_data(pend_data),
        .pend_be(pend_be), .fwd_word(fwd_word)
    );

    lsw_array #(.W(W), .DEPTH(DEPTH), .AW(AW), .L(L)) u_array (
        .clk(clk), .wr_en(commit), .wr_addr(pend_addr), .wr_data(pend_data),
        .wr_be(pend_be), .rd_addr(addr_q), .rd_word(arr_word)
    );

    lsw_out_stage #(.W(W)) u_out (
        .clk(clk), .rst(rst), .rd_now(op_q == OP_READ), .rd_word(fwd_word),
        .out_en(out_en), .dout(dout), .dq_vld(dq_vld), .drv_on(drv_on)
    );
endmodule

// File: rtl/lsw_sram_chk.sv
module lsw_sram_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic we,
    input logic sleep,
    input logic out_en,
    input logic dq_vld,
    input logic drv_on,
    input logic pend_vld,
    input logic cmd_busy
);
    logic rd_acc;
    logic wr_acc;
    assign rd_acc = sel && !we && !sleep;
    assign wr_acc = sel && we && !sleep;

    // R1
    read_drives_chk: assert property (@(posedge clk) disable iff (rst)
        rd_acc |-> ##3 drv_on);

    // R7
    dcd_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_acc ##1 !rd_acc) |-> ##3 !drv_on);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> !dq_vld);

    // R9
    sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !cmd_busy);

    // R6
    write_buffered_chk: assert property (@(posedge clk) disable iff (rst)
        wr_acc |-> ##2 pend_vld);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!drv_on && !pend_vld));
endmodule

bind lsw_sram lsw_sram_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .sleep(sleep),
    .out_en(out_en), .dq_vld(dq_vld), .drv_on(drv_on),
    .pend_vld(pend_vld), .cmd_busy(op_q != lsw_pkg::OP_IDLE)
);

// File: tb/lsw_sram_bench.sv
module lsw_sram_bench;
    localparam int W  = 36;
    localparam int D  = 64;
    localparam int AW = $clog2(D);
    localparam int L  = W / 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [L-1:0]  be = '0;
    logic [W-1:0]  din = '0;
    logic          out_en = 1'b1;
    logic          sleep = 1'b0;
    logic [W-1:0]  dout;
    logic          dq_vld;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] ref_mem [D];
    logic [W-1:0] lw_d = '0;
    logic [L-1:0] lw_b = '0;

    always #2.5 clk = ~clk;

    lsw_sram #(.W(W), .DEPTH(D)) u_lsw_sram (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .be(be),
        .din(din), .out_en(out_en), .sleep(sleep), .dout(dout), .dq_vld(dq_vld)
    );

    task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic w, input logic [AW-1:0] a,
                       input logic [W-1:0] d, input logic [L-1:0] b);
        din  = lw_d;
        be   = lw_b;
        sel  = s;
        we   = w;
        addr = a;
        if (s && w && !sleep) begin
            for (int i = 0; i < L; i++)
                if (b[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
            lw_d = d;
            lw_b = b;
        end else begin
            lw_d = '0;
            lw_b = '0;
        end
        @(negedge clk);
    endtask

    task automatic nop();
        cyc(1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [L-1:0] b);
        cyc(1'b1, 1'b1, a, d, b);
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input string tag);
        logic [W-1:0] exp;
        exp = ref_mem[a];
        cyc(1'b1, 1'b0, a, '0, '0);
        nop();
        nop();
        chk(dq_vld === 1'b1, tag, {35'd0, dq_vld}, 36'd1);
        chk(dout === exp, tag, dout, exp);
    endtask

    task automatic t_reset();
        chk(dq_vld === 1'b0, "R10 dq_vld after reset", {35'd0, dq_vld}, 36'd0);
        chk(dout === '0, "R10 dout after reset", dout, '0);
    endtask

    task automatic t_basic();
        wr(6'd5, 36'h1_2345_6789, 4'b1111);
        nop(); nop();
        rd_expect(6'd5, "R1 R2 read after settled write");
        wr(6'd20, 36'h0_0000_00AB, 4'b1111);
        wr(6'd21, 36'hF_FFFF_FFFF, 4'b1111);
        nop(); nop();
        rd_expect(6'd20, "R2 late data for first of pair");
    endtask

    task automatic t_coherent();
        wr(6'd7, 36'hA_BCDE_F012, 4'b1111);
        rd_expect(6'd7, "R5 read right after write");
        wr(6'd9, 36'h1_1111_1111, 4'b1111);
        wr(6'd9, 36'h2_2222_2222, 4'b0101);
        rd_expect(6'd9, "R3 R5 partial merge while pending");
        wr(6'd9, 36'h7_7777_7777, 4'b1000);
        nop(); nop();
        rd_expect(6'd9, "R4 top lane 35:27 write");
    endtask

    task automatic t_b2b();
        for (int i = 0; i < 4; i++)
            wr(6'(30 + i), 36'(64'h0_1000_0001 * (i + 3)), 4'b1111);
        wr(6'd40, 36'h5_5555_5555, 4'b0011);
        nop();
        for (int i = 0; i < 4; i++)
            rd_expect(6'(30 + i), "R6 back-to-back writes");
    endtask

    task automatic t_dcd();
        logic [W-1:0] exp;
        exp = ref_mem[5];
        cyc(1'b1, 1'b0, 6'd5, '0, '0);
        nop(); nop();
        chk(dq_vld === 1'b1 && dout === exp, "R7 output cycle", dout, exp);
        nop();
        chk(dq_vld === 1'b1, "R7 extra driven cycle", {35'd0, dq_vld}, 36'd1);
        chk(dout === exp, "R7 held data", dout, exp);
        nop();
        chk(dq_vld === 1'b0, "R7 release", {35'd0, dq_vld}, 36'd0);
    endtask

    task automatic t_oe();
        cyc(1'b1, 1'b0, 6'd7, '0, '0);
        nop(); nop();
        out_en = 1'b0;
        #1;
        chk(dq_vld === 1'b0, "R8 async disable", {35'd0, dq_vld}, 36'd0);
        out_en = 1'b1;
        #1;
        chk(dq_vld === 1'b1, "R8 async enable", {35'd0, dq_vld}, 36'd1);
        nop(); nop(); nop();
    endtask

    task automatic t_sleep();
        logic [W-1:0] keep;
        keep = ref_mem[5];
        sleep = 1'b1;
        wr(6'd5, 36'h0_DEAD_BEEF, 4'b1111);
        nop();
        cyc(1'b1, 1'b0, 6'd5, '0, '0);
        nop(); nop();
        chk(dq_vld === 1'b0, "R9 read ignored in sleep", {35'd0, dq_vld}, 36'd0);
        sleep = 1'b0;
        nop();
        chk(ref_mem[5] === keep, "R9 model unchanged", ref_mem[5], keep);
        rd_expect(6'd5, "R9 contents held");
        nop(); nop();
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_basic();
        t_coherent();
        t_b2b();
        nop(); nop(); nop();
        t_dcd();
        t_oe();
        t_sleep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule